// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This block is a down-counting watchdog with a small memory-mapped register port. Software writes a reload value and a control word, then keeps the timer alive by writing a fixed key to a restart register. The key copies the reload value into the counter. If software stops restarting the timer, the counter eventually runs out. When that happens the block produces a one-cycle expiry pulse. Depending on the control word, the expiry also sets an interrupt flag, requests a reset with an encoded scope, and triggers a separate external-pulse stage.

The counter steps down either on every bus clock or only on cycles where a 1 MHz tick enable is high. A control bit picks which of the two is used. When the counter is stepped while it holds zero, the block raises the expiry pulse, reloads the counter from the reload register and keeps counting. The boot-secondary flag is passed straight to the boot-source remapping logic, which lives outside this block.

Top module: `wdt_timer`

## Requirements
- R1: After the synchronous reset, the counter and the reload register both hold the parameter RLD_RST. The control word is zero, and all event outputs and the read data are low.
- R2: The register port decodes address bits [3:2]. Offset 0x00 reads the current count, 0x04 reads and writes the reload value, 0x08 is the restart register, and 0x0C reads and writes the control word. The control word is 8 bits and reads back with its upper bits zero. The restart register reads as zero. Read data is registered and shows the addressed value as it stood in the previous cycle.
- R3: A write of exactly 0x00004755 to offset 0x08 loads the counter from the reload register, clears the interrupt flag, and suppresses expiry in that cycle. A write of any other value to that offset has no effect.
- R4: While control bit 0 (enable) is clear, the counter holds its value and no expiry occurs. Setting enable does not reload the counter.
- R5: When control bit 4 is set, the counter steps only in cycles where the tick input is high. When bit 4 is clear, it steps on every clock.
- R6: A step taken while the count is zero raises the expiry output for one cycle and reloads the counter from the reload register. A step taken at any other count decrements the counter by one. A count of N therefore expires on the (N+1)-th step.
- R7: If control bit 2 is set at expiry, the interrupt flag output is set and stays set until a valid restart key is written.
- R8: If control bit 1 is set at expiry, the reset request output pulses together with the expiry output.
- R9: If control bit 3 is set at expiry, the external trigger output pulses together with the expiry output.
- R10: The reset scope output follows control bits 6:5 one cycle late: code 0 selects the SoC, 1 the full chip and 2 the CPU only. The reserved code 3 is output as 0.
- R11: The boot-secondary output equals control bit 7 as it is stored.
- R12: Writes to offset 0x00 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1m | input | 1 | 1 MHz tick enable, one clock wide |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| expire_o | output | 1 | One-cycle expiry pulse |
| irq_o | output | 1 | Sticky interrupt flag |
| rst_req_o | output | 1 | Reset request pulse |
| rst_scope_o | output | 2 | Encoded reset scope |
| ext_trig_o | output | 1 | Trigger for the external pulse stage |
| boot_sec_o | output | 1 | Boot-secondary flag |

## Verification
The first test uses a short reload with every action enabled and stepping on every clock. It checks when expiry happens and that the counter reloads and keeps running. A reload of zero gives back-to-back expiries. This shows that the reload happens on the step taken at zero, not one step earlier. Near-miss keys and a write to the read-only offset must leave the count and the flag untouched, while the exact key must clear the flag. Toggling enable shows the difference between freezing and reloading. Sparse tick pulses with tick selection on separate clock-rate counting from tick counting. The scope codes 2 and 3, and the boot bit, are walked to check how the scope is decoded.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [31:0] KICK_KEY = 32'h0000_4755;

  localparam logic [1:0] WORD_COUNT  = 2'd0;
  localparam logic [1:0] WORD_RELOAD = 2'd1;
  localparam logic [1:0] WORD_KICK   = 2'd2;
  localparam logic [1:0] WORD_CTRL   = 2'd3;

  typedef struct packed {
    logic       boot;
    logic [1:0] scope;
    logic       tick_sel;
    logic       ext;
    logic       irq;
    logic       rst;
    logic       en;
  } ctrl_t;

  function automatic logic [1:0] scope_map(input logic [1:0] code);
    return (code == 2'd3) ? 2'd0 : code;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [DATA_W-1:0] RLD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] reload,
  output ctrl_t             ctrl,
  output logic              kick,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] rd_mux;

  assign word = addr[ADDR_W-1:2];
  assign kick = wr && (word == WORD_W'(WORD_KICK)) && (wdata == DATA_W'(KICK_KEY));

  always_comb begin
    rd_mux = '0;
    if (word == WORD_W'(WORD_COUNT))  rd_mux = count;
    if (word == WORD_W'(WORD_RELOAD)) rd_mux = reload;
    if (word == WORD_W'(WORD_CTRL))   rd_mux = DATA_W'(ctrl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= RLD_RST;
      ctrl   <= '0;
      rdata  <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr && word == WORD_W'(WORD_RELOAD)) reload <= wdata;
      if (wr && word == WORD_W'(WORD_CTRL))   ctrl   <= ctrl_t'(wdata[7:0]);
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] RLD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick_sel,
  input  logic              tick,
  input  logic              kick,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] count,
  output logic              hit
);
  logic step;

  assign step = en && (tick_sel ? tick : 1'b1);
  assign hit  = step && !kick && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= RLD_RST;
    end else if (kick || hit) begin
      count <= reload;
    end else if (step) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_events.sv
module wdt_events
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       kick,
  input  ctrl_t      ctrl,
  output logic       expire_o,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       ext_trig_o,
  output logic [1:0] rst_scope_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      expire_o    <= 1'b0;
      irq_o       <= 1'b0;
      rst_req_o   <= 1'b0;
      ext_trig_o  <= 1'b0;
      rst_scope_o <= 2'd0;
    end else begin
      expire_o    <= hit;
      rst_req_o   <= hit && ctrl.rst;
      ext_trig_o  <= hit && ctrl.ext;
      rst_scope_o <= scope_map(ctrl.scope);
      if (kick)                  irq_o <= 1'b0;
      else if (hit && ctrl.irq)  irq_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [DATA_W-1:0] RLD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1m,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              expire_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic [1:0]        rst_scope_o,
  output logic              ext_trig_o,
  output logic              boot_sec_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload;
  logic [DATA_W-1:0] count;
  logic              kick;
  logic              hit;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RLD_RST(RLD_RST)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .count(count), .reload(reload), .ctrl(ctrl), .kick(kick), .rdata(bus_rdata)
  );

  wdt_counter #(.DATA_W(DATA_W), .RLD_RST(RLD_RST)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl.en), .tick_sel(ctrl.tick_sel), .tick(tick_1m),
    .kick(kick), .reload(reload), .count(count), .hit(hit)
  );

  wdt_events u_evt (
    .clk(clk), .rst(rst), .hit(hit), .kick(kick), .ctrl(ctrl),
    .expire_o(expire_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
    .ext_trig_o(ext_trig_o), .rst_scope_o(rst_scope_o)
  );

  assign boot_sec_o = ctrl.boot;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              en,
  input logic              expire,
  input logic              irq,
  input logic              rst_req,
  input logic              ext_trig,
  input logic [1:0]        scope,
  input logic              boot
);
  logic is_kick;
  logic is_ctrl_wr;

  assign is_kick    = wr && (addr[ADDR_W-1:2] == (ADDR_W-2)'(2)) && (wdata == DATA_W'(32'h4755));
  assign is_ctrl_wr = wr && (addr[ADDR_W-1:2] == (ADDR_W-2)'(3));

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    is_kick |=> (!expire && !irq)); // R3
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !expire); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> expire); // R7
  AST_RST_WITH_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> expire); // R8
  AST_EXT_WITH_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    ext_trig |-> expire); // R9
  AST_SCOPE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    scope != 2'd3); // R10
  AST_BOOT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    is_ctrl_wr |=> (boot == $past(wdata[7]))); // R11
endmodule

bind wdt_timer wdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
  .en(ctrl.en), .expire(expire_o), .irq(irq_o), .rst_req(rst_req_o),
  .ext_trig(ext_trig_o), .scope(rst_scope_o), .boot(boot_sec_o)
);

// File: tb/sim_wdt_timer.sv
module sim_wdt_timer;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam logic [31:0] LOAD0 = 32'd40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          expire, irq, rst_req, ext_trig, boot;
  logic [1:0]    scope;

  always #5 clk = ~clk;

  wdt_timer #(.DATA_W(DW), .ADDR_W(AW), .RLD_RST(LOAD0)) u0 (
    .clk(clk), .rst(rst), .tick_1m(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .expire_o(expire), .irq_o(irq),
    .rst_req_o(rst_req), .rst_scope_o(scope), .ext_trig_o(ext_trig),
    .boot_sec_o(boot)
  );

  // behavioural reference state
  logic [31:0] m_cnt, m_rld, m_rdata, o_cnt, o_rld;
  logic [7:0]  m_ctrl, o_ctrl;
  logic        m_irq, m_exp, m_rst, m_ext, step, kick;
  logic [1:0]  m_scope;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;
  string       rd_tag = "R2";

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = LOAD0; m_rld = LOAD0; m_ctrl = 8'h00; m_rdata = 0;
      m_irq = 0; m_exp = 0; m_rst = 0; m_ext = 0; m_scope = 0;
    end else begin
      o_cnt = m_cnt; o_rld = m_rld; o_ctrl = m_ctrl;
      case (addr[3:2])
        2'd0:    m_rdata = o_cnt;
        2'd1:    m_rdata = o_rld;
        2'd3:    m_rdata = {24'h0, o_ctrl};
        default: m_rdata = 0;
      endcase
      kick = wr && addr[3:2] == 2'd2 && wdata == 32'h0000_4755;
      step = o_ctrl[0] && (o_ctrl[4] ? tick : 1'b1);
      m_exp = 0;
      if (kick) begin
        m_cnt = o_rld; m_irq = 0;
      end else if (step) begin
        if (o_cnt == 0) begin m_exp = 1; m_cnt = o_rld; end
        else m_cnt = o_cnt - 1;
      end
      if (m_exp && o_ctrl[2]) m_irq = 1;
      m_rst = m_exp && o_ctrl[1];
      m_ext = m_exp && o_ctrl[3];
      m_scope = (o_ctrl[6:5] == 2'd3) ? 2'd0 : o_ctrl[6:5];
      if (wr && addr[3:2] == 2'd1) m_rld = wdata;
      if (wr && addr[3:2] == 2'd3) m_ctrl = wdata[7:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(rd_tag, rdata, m_rdata);
      check("R6 expire", 32'(expire), 32'(m_exp));
      check("R7 irq", 32'(irq), 32'(m_irq));
      check("R8 rst_req", 32'(rst_req), 32'(m_rst));
      check("R9 ext_trig", 32'(ext_trig), 32'(m_ext));
      check("R10 scope", 32'(scope), 32'(m_scope));
      check("R11 boot", 32'(boot), 32'(m_ctrl[7]));
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 4'h0; wdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] snap;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    check("R1 count", rdata, LOAD0);
    check("R1 outs", {27'h0, expire, irq, rst_req, ext_trig, boot}, 32'h0);

    rd_tag = "R6";
    bus_write(4'h4, 32'd6);
    bus_write(4'hC, 32'h2F);
    bus_write(4'h8, 32'h4755);
    idle(20);
    check("R7 irq sticky", 32'(irq), 32'd1);

    rd_tag = "R3";
    bus_write(4'h8, 32'h4756);
    bus_write(4'h8, 32'h0001_4755);
    idle(1);
    check("R3 bad key keeps irq", 32'(irq), 32'd1);
    bus_write(4'h4, 32'd30);
    bus_write(4'h8, 32'h4755);
    idle(1);
    check("R3 key clears irq", 32'(irq), 32'd0);
    idle(2);

    rd_tag = "R4";
    bus_write(4'hC, 32'h2E);
    idle(2);
    snap = rdata;
    idle(6);
    check("R4 frozen", rdata, snap);
    bus_write(4'hC, 32'h2F);
    idle(3);
    check("R4 no reload on enable", 32'(rdata < snap), 32'd1);

    rd_tag = "R5";
    bus_write(4'hC, 32'h3F);
    idle(5);
    snap = rdata;
    idle(4);
    check("R5 no tick holds", rdata, snap);
    bus_write(4'h4, 32'd3);
    bus_write(4'h8, 32'h4755);
    for (int i = 0; i < 40; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    tick = 1'b0;

    rd_tag = "R6";
    bus_write(4'h4, 32'd0);
    bus_write(4'hC, 32'h0F);
    bus_write(4'h8, 32'h4755);
    idle(5);

    rd_tag = "R10";
    bus_write(4'h4, 32'd5);
    bus_write(4'hC, 32'h4B);
    idle(8);
    bus_write(4'hC, 32'h6B);
    idle(8);
    check("R10 reserved code", 32'(scope), 32'd0);

    rd_tag = "R11";
    bus_write(4'hC, 32'hAB);
    idle(3);
    check("R11 boot set", 32'(boot), 32'd1);

    rd_tag = "R12";
    bus_write(4'hC, 32'h00);
    idle(2);
    snap = rdata;
    bus_write(4'h0, 32'h1234_5678);
    idle(2);
    check("R12 ro write", rdata, snap);

    rd_tag = "R2";
    addr = 4'h4; idle(2);
    check("R2 reload readback", rdata, 32'd5);
    addr = 4'hC; idle(2);
    check("R2 ctrl readback", rdata, 32'h0);
    addr = 4'h8; idle(2);
    check("R2 kick reads zero", rdata, 32'h0);
    addr = 4'h0;
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule